// File: doc/BRIEF.md
# Periodic Miss Address Sampler

This block watches bus read and exchange transactions that cache misses cause. Every so often it freezes the address and type of one of them into a 64-bit read-only status word, so software can see where miss traffic goes without logging every transaction. Each qualifying transaction steps a shared counter that runs freely modulo 64. The word has two independent 32-bit sample slots, low and high. Each slot captures at its own counter phase, and the two phases are 62 counts apart.

A slot that has captured holds its sample and raises its valid flag. It then ignores all later traffic until software clears that flag with a write-one-to-clear strobe. Clearing does not reset the counter, so a cleared slot fills again somewhere between 1 and 64 qualifying transactions later. The valid flags are also exported on their own pins, so a separate control register can mirror them.

Top module: `miss_addr_sampler`

## Requirements
- R1: A transaction qualifies only when `txn_stb` is 1 and `txn_skip_bit` is 0. Each qualifying transaction advances the sample counter by exactly one, wrapping from 63 to 0. Any other cycle leaves the counter unchanged. The counter starts at 0 after reset.
- R2: A slot captures a qualifying transaction when the counter value at that transaction equals the slot's phase and the slot's valid flag is 0. The captured address, the type and valid=1 appear on `reg_rdata` in the cycle after the transaction.
- R3: While a slot's valid flag is 1, its address and type fields do not change, whatever traffic arrives.
- R4: The low slot's phase is counter value 0. The high slot's phase is counter value 62. A sample is taken only at a slot's phase.
- R5: A 1 on `clr_lo` or `clr_hi` sets that slot's valid flag to 0 from the next cycle and leaves its data fields and the counter untouched. The slot next captures at the first later qualifying transaction that meets its phase.
- R6: If a clear and a capture for the same slot fall in the same cycle, the capture wins and the valid flag ends up 1.
- R7: Word layout. `reg_rdata[31:2]` is the low-slot address, bit 1 is the low-slot type and bit 0 is the low-slot valid flag. Bits [63:34], 33 and 32 hold the same fields for the high slot. The type is 1 for a read and 0 for an exchange.
- R8: Synchronous active-low reset sets both valid flags to 0. It also sets the address and type fields to 0, but software must treat those fields as undefined while valid is 0.
- R9: `valid_flags[0]` always equals `reg_rdata[0]`, and `valid_flags[1]` always equals `reg_rdata[32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_stb | input | 1 | One-cycle strobe for a miss-caused read or exchange |
| txn_addr | input | 30 | Address bits of the transaction |
| txn_read | input | 1 | 1 = read, 0 = exchange |
| txn_skip_bit | input | 1 | Qualifying address bit; a set bit excludes the transaction |
| clr_lo | input | 1 | Write-one-to-clear strobe for the low slot's valid flag |
| clr_hi | input | 1 | Write-one-to-clear strobe for the high slot's valid flag |
| reg_rdata | output | 64 | Read value of the status word |
| valid_flags | output | 2 | Valid flags, bit 0 = low slot, bit 1 = high slot |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge before any traffic. They also assume that `txn_addr`, `txn_read` and the clear strobes are known (not X) on every edge where they matter, and they treat each cycle with a strobe as exactly one transaction. The bench drives every input at the falling edge and holds it at a defined value through the whole run, with reset asserted from time zero. In its directed phases it places clears exactly on the capture cycle and spreads excluded strobes between qualifying ones. The random phase draws only 0/1 values for strobes and clears.

// File: rtl/msamp_pkg.sv
// Package: shared constants and types for the periodic miss address sampler.
// Assumes two sample slots, low first, in the status word.
package msamp_pkg;

    localparam int NUM_SLOTS = 2;
    localparam int SLOT_LO   = 0;
    localparam int SLOT_HI   = 1;

    // Transaction kind as stored in the type bit of a slot.
    typedef enum logic {
        TXN_XCHG = 1'b0,
        TXN_READ = 1'b1
    } txn_kind_e;

endpackage

// File: rtl/msamp_counter.sv
// Module: msamp_counter
// Free-running modulo-PERIOD counter of qualifying transactions.
// Assumes adv_i is high for exactly one cycle per qualifying transaction.
// Only reset clears the counter; nothing else reloads it.
module msamp_counter #(
    parameter int PERIOD = 64,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Step by one per qualifying transaction and wrap after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R1: no qualifying transaction means no movement
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(cnt_o));

    // R1: each qualifying transaction moves the count one step, with wrap
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (cnt_o == (($past(cnt_o) == LAST) ? '0 : $past(cnt_o) + 1'b1)));

endmodule

// File: rtl/msamp_slot.sv
// Module: msamp_slot
// One 32-bit sample slot: {address, type, valid}. Captures when a qualifying
// transaction arrives at this slot's counter phase while the slot is empty,
// then holds until a write-one-to-clear strobe. A capture beats a clear.
// Assumes cnt_i is the counter value before this transaction is counted.
module msamp_slot
    import msamp_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 6,
    parameter int PHASE  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qual_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  txn_kind_e         kind_i,
    input  logic              clr_i,
    output logic [ADDR_W+1:0] word_o,
    output logic              valid_o
);

    localparam logic [CNT_W-1:0] PH = CNT_W'(PHASE);

    logic [ADDR_W-1:0] addr_q;
    txn_kind_e         kind_q;
    logic              valid_q;
    logic              take;

    // Capture condition: right phase, qualifying transaction, slot empty.
    always_comb begin
        take = qual_i && (cnt_i == PH) && !valid_q;
    end

    // Data fields load only on a capture; reset zeroes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            kind_q <= TXN_XCHG;
        end else if (take) begin
            addr_q <= addr_i;
            kind_q <= kind_i;
        end
    end

    // Valid flag: set by capture, cleared by strobe, capture first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (take) begin
            valid_q <= 1'b1;
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end
    end

    assign word_o  = {addr_q, kind_q, valid_q};
    assign valid_o = valid_q;

    // R2: a capture shows the transaction with valid set one cycle later
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_i && (cnt_i == PH) && !valid_o) |=>
            (valid_o && (word_o[ADDR_W+1:2] == $past(addr_i)) && (word_o[1] == $past(kind_i))));

    // R3: a full slot keeps its fields
    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> $stable(word_o[ADDR_W+1:1]));

    // R4: the flag only rises after a qualifying transaction at this phase
    p_phase_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(qual_i && (cnt_i == PH)));

    // R5: a clear with no capture empties the slot
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(qual_i && (cnt_i == PH))) |=> !valid_o);

    // R6: a capture that meets a clear still fills the slot
    p_capture_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && qual_i && (cnt_i == PH) && !valid_o) |=> valid_o);

endmodule

// File: rtl/miss_addr_sampler.sv
// Module: miss_addr_sampler (top)
// Periodic sampler of miss-caused read/exchange addresses into a 64-bit
// read-only word made of two slots that capture at counter phases
// HI_SKEW apart. Assumes txn_stb marks one bus transaction per cycle and
// that the caller has already filtered it to miss-caused reads/exchanges.
module miss_addr_sampler
    import msamp_pkg::*;
#(
    parameter int ADDR_W   = 30,
    parameter int PERIOD   = 64,
    parameter int LO_PHASE = 0,
    parameter int HI_SKEW  = 62
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          txn_stb,
    input  logic [ADDR_W-1:0]             txn_addr,
    input  logic                          txn_read,
    input  logic                          txn_skip_bit,
    input  logic                          clr_lo,
    input  logic                          clr_hi,
    output logic [NUM_SLOTS*(ADDR_W+2)-1:0] reg_rdata,
    output logic [NUM_SLOTS-1:0]          valid_flags
);

    localparam int SLOT_W = ADDR_W + 2;
    localparam int CNT_W  = $clog2(PERIOD);

    logic                 qual;
    logic [CNT_W-1:0]     cnt;
    logic [NUM_SLOTS-1:0] clr_vec;
    txn_kind_e            kind;

    // Qualify the strobe and gather per-slot clears.
    always_comb begin
        qual    = txn_stb && !txn_skip_bit;
        clr_vec = {clr_hi, clr_lo};
        kind    = txn_kind_e'(txn_read);
    end

    msamp_counter #(
        .PERIOD (PERIOD)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (qual),
        .cnt_o (cnt)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int PH = (s == SLOT_LO) ? LO_PHASE : (LO_PHASE + HI_SKEW) % PERIOD;

        msamp_slot #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .PHASE  (PH)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .qual_i  (qual),
            .cnt_i   (cnt),
            .addr_i  (txn_addr),
            .kind_i  (kind),
            .clr_i   (clr_vec[s]),
            .word_o  (reg_rdata[s*SLOT_W +: SLOT_W]),
            .valid_o (valid_flags[s])
        );
    end

    // R8: reset leaves both slots empty and the word zero
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> ((valid_flags == '0) && (reg_rdata == '0)));

    // R9: exported flags mirror the valid bits of the word
    p_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_flags == {reg_rdata[SLOT_W], reg_rdata[0]});

endmodule

// File: tb/miss_addr_sampler_tb_top.sv
`timescale 1ns/1ps
module miss_addr_sampler_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_stb = 1'b0;
    logic [29:0] txn_addr = '0;
    logic        txn_read = 1'b0;
    logic        txn_skip_bit = 1'b0;
    logic        clr_lo = 1'b0;
    logic        clr_hi = 1'b0;
    logic [63:0] reg_rdata;
    logic [1:0]  valid_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Behavioural reference state
    int          m_cnt = 0;
    logic [31:0] m_lo = '0;
    logic [31:0] m_hi = '0;

    always #2 clk = ~clk;

    miss_addr_sampler dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_stb      (txn_stb),
        .txn_addr     (txn_addr),
        .txn_read     (txn_read),
        .txn_skip_bit (txn_skip_bit),
        .clr_lo       (clr_lo),
        .clr_hi       (clr_hi),
        .reg_rdata    (reg_rdata),
        .valid_flags  (valid_flags)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output with the reference model.
    task automatic compare_all();
        check("R2 R3 R5 R6 R7 low slot", {32'b0, reg_rdata[31:0]}, {32'b0, m_lo});
        check("R2 R3 R4 R5 R6 R7 high slot", {32'b0, reg_rdata[63:32]}, {32'b0, m_hi});
        check("R9 valid flags", {62'b0, valid_flags}, {62'b0, m_hi[0], m_lo[0]});
    endtask

    // One clock: drive inputs, advance the model, check after the edge.
    task automatic cyc(input logic stb, input logic skip, input logic [29:0] a,
                       input logic rd, input logic cl, input logic ch);
        logic q;
        txn_stb = stb; txn_skip_bit = skip; txn_addr = a; txn_read = rd;
        clr_lo = cl; clr_hi = ch;
        q = stb && !skip;
        if (q && m_cnt == 0 && !m_lo[0]) m_lo = {a, rd, 1'b1};
        else if (cl) m_lo[0] = 1'b0;
        if (q && m_cnt == 62 && !m_hi[0]) m_hi = {a, rd, 1'b1};
        else if (ch) m_hi[0] = 1'b0;
        if (q) m_cnt = (m_cnt + 1) % 64;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset word", reg_rdata, 64'h0);
        check("R8 reset flags", {62'b0, valid_flags}, 64'h0);
        rst_n = 1'b1;

        // R1 R4: qualifying transactions with excluded strobes in between
        for (int i = 0; i < 70; i++) begin
            cyc(1'b1, 1'b0, 30'(i), i[0], 1'b0, 1'b0);
            cyc(1'b1, 1'b1, 30'h3FFFFFFF, 1'b1, 1'b0, 1'b0);
            if (i % 7 == 0) cyc(1'b0, 1'b0, 30'h15555555, 1'b1, 1'b0, 1'b0);
        end
        check("R2 R7 low holds first transaction", {32'b0, reg_rdata[31:0]}, {32'b0, 30'd0, 1'b0, 1'b1});
        check("R1 R4 high holds transaction 62", {32'b0, reg_rdata[63:32]}, {32'b0, 30'd62, 1'b0, 1'b1});

        // R5: clear low at count 6; the next low capture is at count 0
        cyc(1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0);
        check("R5 low cleared", {62'b0, valid_flags}, 64'h2);
        check("R5 low data kept", {34'b0, reg_rdata[31:2]}, 64'h0);
        for (int j = 0; j < 64; j++) cyc(1'b1, 1'b0, 30'(100 + j), 1'b1, 1'b0, 1'b0);
        check("R5 counter not reset by clear", {32'b0, reg_rdata[31:0]}, {32'b0, 30'd158, 1'b1, 1'b1});

        // R6: clear high, then clear again on the very capture cycle
        cyc(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1);
        for (int j = 0; j < 56; j++) cyc(1'b1, 1'b0, 30'(500 + j), 1'b1, 1'b0, 1'b0);
        check("R6 high still empty before phase", {63'b0, valid_flags[1]}, 64'h0);
        cyc(1'b1, 1'b0, 30'h2AAAAAAA, 1'b0, 1'b0, 1'b1);
        check("R6 capture beats clear", {32'b0, reg_rdata[63:32]}, {32'b0, 30'h2AAAAAAA, 1'b0, 1'b1});

        // Mixed random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) == 0),
                30'($urandom), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 40) == 0), 1'($urandom_range(0, 40) == 0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule